// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for every beat of a four-beat burst into a synchronous SRAM. A burst opens when either of two start strobes is sampled high on a rising clock edge. One strobe comes from a processor and the other from a cache controller. On that edge the block captures the external start address and the order-select input. The first beat then appears at the outputs.

On each later edge where the advance input is high and no strobe is present, a two-bit beat counter steps by one. The two low address bits then follow one of two orders, chosen by the order-select value captured at the start. Linear order adds the beat count to the starting low bits, modulo 4. Interleaved order XORs the beat count into the starting low bits. The upper address bits stay fixed for the whole burst. The outputs are the full current address, the beat index, and a flag that records which strobe opened the current burst.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the registers clear. After that edge `addr_out` is 0, `beat_idx` is 0 and `start_by_cache` is 0.
- R2: A high `strobe_proc` at an edge loads `addr_in`. After that edge `addr_out` equals the loaded address, `beat_idx` is 0 and `start_by_cache` is 0.
- R3: A high `strobe_cache` with a low `strobe_proc` at an edge loads `addr_in` in the same way. After that edge `start_by_cache` is 1.
- R4: When both strobes are high at the same edge, the processor strobe wins and `start_by_cache` is 0 after that edge.
- R5: With both strobes low and `advance` high at an edge, `beat_idx` steps by one modulo 4, so beat 3 is followed by beat 0.
- R6: When `order_sel` was 0 at the start of the burst (linear order), `addr_out[1:0]` equals the starting low bits plus `beat_idx`, modulo 4.
- R7: When `order_sel` was 1 at the start of the burst (interleaved order), `addr_out[1:0]` equals the starting low bits XOR `beat_idx`.
- R8: Without a strobe, `addr_out[ADDR_W-1:2]` does not change.
- R9: With both strobes low and `advance` low at an edge, `addr_out`, `beat_idx` and `start_by_cache` keep their values.
- R10: A strobe takes priority over `advance`. A strobe in the middle of a burst reloads the address and returns `beat_idx` to 0, even when `advance` is high.
- R11: `order_sel` takes effect only at an edge where a strobe is sampled. Changing it in the middle of a burst does not alter the order of the remaining beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | External burst start address |
| strobe_proc | input | 1 | Burst start strobe from the processor (higher priority) |
| strobe_cache | input | 1 | Burst start strobe from the cache controller |
| advance | input | 1 | Steps the beat count when no strobe is present |
| order_sel | input | 1 | 0 selects linear order, 1 selects interleaved order; sampled with a strobe |
| addr_out | output | ADDR_W | Address of the current beat |
| beat_idx | output | 2 | Position of the current beat within the burst |
| start_by_cache | output | 1 | 1 when the cache-controller strobe opened the current burst |

## Verification
The hardest situation to reach is a burst started in one order that then has `order_sel` flipped before its remaining beats, while a competing strobe or advance arrives on the same edge. The stimulus starts interleaved bursts from every starting low value, toggles `order_sel` between advances, and then drives a mid-burst strobe together with `advance`. Both strobes are also raised together to expose the source priority. The counter is driven past beat 3 to show the wrap.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    typedef enum logic {
        SRC_PROC  = 1'b0,
        SRC_CACHE = 1'b1
    } src_e;

    typedef struct packed {
        logic load;
        src_e src;
    } start_req_t;

    function automatic beat_t map_low(beat_t start, beat_t beat, order_e ord);
        beat_t r;
        if (ord == ORD_XOR) r = start ^ beat;
        else                r = start + beat;
        return r;
    endfunction

endpackage

// File: rtl/burst_start_arb.sv
module burst_start_arb
    import burst_seq_pkg::*;
(
    input  logic       strobe_proc,
    input  logic       strobe_cache,
    output start_req_t req
);
    always_comb begin
        req.load = strobe_proc | strobe_cache;
        req.src  = strobe_proc ? SRC_PROC : SRC_CACHE;
    end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  step,
    output beat_t beat
);
    beat_t beat_q;

    always_ff @(posedge clk) begin
        if (rst)       beat_q <= '0;
        else if (load) beat_q <= '0;
        else if (step) beat_q <= beat_q + beat_t'(1);
    end

    assign beat = beat_q;

    // R5: the counter steps by one when advancing without a load
    p_beat_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && step) |=> (beat == beat_t'($past(beat) + beat_t'(1))));

    // R9: the counter keeps its value when idle
    p_beat_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(beat));

    // R10: a load returns the counter to zero even while stepping
    p_beat_clear_r10: assert property (@(posedge clk) disable iff (rst)
        load |=> (beat == '0));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_proc,
    input  logic              strobe_cache,
    input  logic              advance,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out,
    output logic [BEAT_W-1:0] beat_idx,
    output logic              start_by_cache
);
    localparam int HI_W = ADDR_W - BEAT_W;

    start_req_t        req;
    beat_t             beat;
    logic [HI_W-1:0]   hi_q;
    beat_t             lo_start_q;
    order_e            ord_q;
    src_e              src_q;
    beat_t             lo_now;

    burst_start_arb u_arb (
        .strobe_proc  (strobe_proc),
        .strobe_cache (strobe_cache),
        .req          (req)
    );

    burst_beat_ctr u_ctr (
        .clk  (clk),
        .rst  (rst),
        .load (req.load),
        .step (advance),
        .beat (beat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q       <= '0;
            lo_start_q <= '0;
            ord_q      <= ORD_LINEAR;
            src_q      <= SRC_PROC;
        end else if (req.load) begin
            hi_q       <= addr_in[ADDR_W-1:BEAT_W];
            lo_start_q <= addr_in[BEAT_W-1:0];
            ord_q      <= order_e'(order_sel);
            src_q      <= req.src;
        end
    end

    always_comb lo_now = map_low(lo_start_q, beat, ord_q);

    assign addr_out       = {hi_q, lo_now};
    assign beat_idx       = beat;
    assign start_by_cache = (src_q == SRC_CACHE);

    // R2: a processor strobe loads the address and opens beat 0
    p_proc_load_r2: assert property (@(posedge clk) disable iff (rst)
        strobe_proc |=> (addr_out == $past(addr_in)) && (beat_idx == '0) && !start_by_cache);

    // R3: a lone cache strobe loads the address and flags its source
    p_cache_load_r3: assert property (@(posedge clk) disable iff (rst)
        (strobe_cache && !strobe_proc) |=> (addr_out == $past(addr_in)) && start_by_cache);

    // R4: the processor strobe wins a tie
    p_proc_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (strobe_proc && strobe_cache) |=> !start_by_cache);

    // R6: linear order steps the low bits by one
    p_linear_step_r6: assert property (@(posedge clk) disable iff (rst)
        (!req.load && advance && ord_q == ORD_LINEAR)
        |=> (addr_out[1:0] == beat_t'($past(addr_out[1:0]) + beat_t'(1))));

    // R7: interleaved order moves the low bits with the beat's bit flips
    p_xor_step_r7: assert property (@(posedge clk) disable iff (rst)
        (!req.load && advance && ord_q == ORD_XOR)
        |=> ((addr_out[1:0] ^ $past(addr_out[1:0])) == (beat_idx ^ $past(beat_idx))));

    // R8: upper address bits stay fixed without a strobe
    p_upper_fixed_r8: assert property (@(posedge clk) disable iff (rst)
        !req.load |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

    // R9: nothing moves when idle
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!req.load && !advance) |=> $stable(addr_out) && $stable(start_by_cache));

    // R11: the captured order is kept between strobes
    p_order_kept_r11: assert property (@(posedge clk) disable iff (rst)
        !req.load |=> $stable(ord_q));
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb_top;
    localparam int AW = 20;

    typedef struct {
        logic [AW-1:0] addr;
        logic [1:0]    beat;
        logic          cache;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          strobe_proc = 1'b0;
    logic          strobe_cache = 1'b0;
    logic          advance = 1'b0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat_idx;
    logic          start_by_cache;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    exp_t sb[$];

    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = '0;
    logic          m_ord = 1'b0;
    logic          m_cache = 1'b0;

    always #10 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .addr_in(addr_in),
        .strobe_proc(strobe_proc), .strobe_cache(strobe_cache),
        .advance(advance), .order_sel(order_sel),
        .addr_out(addr_out), .beat_idx(beat_idx), .start_by_cache(start_by_cache)
    );

    task automatic step(input logic r, input logic [AW-1:0] a, input logic sp,
                        input logic sc, input logic adv, input logic ord, input string tag);
        exp_t e;
        logic [1:0] lo;
        @(negedge clk);
        rst = r; addr_in = a; strobe_proc = sp; strobe_cache = sc;
        advance = adv; order_sel = ord;
        if (r) begin
            m_base = '0; m_beat = '0; m_ord = 1'b0; m_cache = 1'b0;
        end else if (sp || sc) begin
            m_base = a; m_beat = '0; m_ord = ord; m_cache = !sp;
        end else if (adv) begin
            m_beat = m_beat + 2'd1;
        end
        lo = m_ord ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        e.addr = {m_base[AW-1:2], lo};
        e.beat = m_beat;
        e.cache = m_cache;
        e.tag = tag;
        sb.push_back(e);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_vec++;
                if (addr_out !== e.addr || beat_idx !== e.beat || start_by_cache !== e.cache) begin
                    n_bad++;
                    $display("FAIL %s: got addr=%h beat=%0d cache=%0b, expected addr=%h beat=%0d cache=%0b",
                             e.tag, addr_out, beat_idx, start_by_cache, e.addr, e.beat, e.cache);
                end
            end
        end
    end

    initial begin
        // R1 reset state
        step(1, 20'hFFFFF, 1, 0, 1, 1, "R1");
        step(1, 20'h00000, 0, 0, 0, 0, "R1");
        // R2 processor start, R6 linear, R5 wrap
        step(0, 20'h12345, 1, 0, 0, 0, "R2");
        for (int i = 0; i < 5; i++) step(0, 20'h0, 0, 0, 1, 0, "R6_R5");
        // R9 hold
        step(0, 20'h55555, 0, 0, 0, 1, "R9");
        step(0, 20'h55555, 0, 0, 0, 1, "R9");
        // R3 cache start, R7 interleaved, R8 upper fixed
        step(0, 20'hABCDE, 0, 1, 0, 1, "R3");
        for (int i = 0; i < 4; i++) step(0, 20'h0, 0, 0, 1, 0, "R7_R8");
        // R7 every starting low value
        for (int s = 0; s < 4; s++) begin
            step(0, 20'h30F0 + AW'(s), 0, 1, 0, 1, "R7");
            for (int i = 0; i < 3; i++) step(0, 20'h0, 0, 0, 1, 0, "R7");
        end
        // R4 both strobes
        step(0, 20'h0777A, 1, 1, 0, 0, "R4");
        step(0, 20'h0, 0, 0, 1, 0, "R4_R6");
        // R11 order change mid-burst
        step(0, 20'h44441, 1, 0, 0, 0, "R11");
        step(0, 20'h0, 0, 0, 1, 1, "R11");
        step(0, 20'h0, 0, 0, 0, 1, "R11");
        step(0, 20'h0, 0, 0, 1, 1, "R11");
        step(0, 20'h22223, 0, 1, 0, 1, "R11");
        step(0, 20'h0, 0, 0, 1, 0, "R11");
        step(0, 20'h0, 0, 0, 1, 0, "R11");
        // R10 strobe with advance mid-burst
        step(0, 20'h9999E, 1, 0, 1, 0, "R10");
        step(0, 20'h0, 0, 0, 1, 0, "R10");
        step(0, 20'h0, 0, 0, 1, 0, "R10");
        step(0, 20'h11112, 0, 1, 1, 1, "R10");
        step(0, 20'h0, 0, 0, 1, 0, "R10");
        // R1 reset mid-burst
        step(1, 20'h0, 0, 0, 1, 0, "R1");
        step(0, 20'h0, 0, 0, 0, 0, "R1");
        step(0, 20'h0, 0, 0, 0, 0, "R9");
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule